// File: doc/BRIEF.md
# USB Host Port Status and Control Register

This block holds the status and control word for one downstream port of a USB host controller. Software writes it through a simple register bus: one write-enable strobe and one 32-bit data word. The current value is always visible on a 32-bit read bus. A single write can act on fields with different semantics:

- a self-clearing start bit that asks for a port reset;
- change flags that software clears by writing 1 to them;
- a link-state field that changes only under a companion strobe, and only for a legal transition;
- plain read/write enable bits.

Port-side logic reports change conditions on a set-request input. The block merges these into the change flags. When a flag newly becomes set while the controller is running, the block emits a one-cycle event request. Reset sequencing itself is not part of this block; it is asked for through a one-cycle reset-request pulse. A debug pulse marks link-state writes that request a value the block does not accept.

Top module: `psr_port_status`

## Requirements
- R1: A write with bit 4 (port reset) set produces a one-cycle `port_reset_req` pulse in the cycle after the write edge. All other bits of that write have no effect, so the read word does not change.
- R2: The change flags occupy bits 23:17, in the order connect, enable, warm reset, over-current, reset, link-state, config-error. Writing 1 to a flag clears it; writing 0 leaves it as it was.
- R3: The link-state field (bits 8:5) takes write data only when bit 16 (link write strobe) of the same write is 1. Otherwise it keeps its value. Bit 16 and bit 4 always read as 0.
- R4: A link write requesting U0 (value 0) takes effect only when the current state is not U0. When it does, the link-state change flag (bit 22) is set. The clear action of the same write is applied first, so the flag ends set even if that write also wrote 1 to bit 22.
- R5: A link write requesting U3 (value 3) takes effect only when the current state is numerically below 3. Otherwise it is ignored.
- R6: A link write requesting Resume (value 15) is silently ignored. A link write requesting any value other than 0, 3 or 15 is ignored, and `pls_dbg_ignored` pulses for one cycle.
- R7: Port power (bit 9) and the three wake enables (bits 27:25) take the written value on every write without the reset bit.
- R8: A change notification, whether from `chg_set` (bit i maps to flag bit 17+i) or from U0 entry, sets the requested flags. `event_req` pulses for one cycle only if at least one requested flag was not already set and `run` is 1.
- R9: After reset the read word is 0 and all pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| run | input | 1 | Controller run bit; gates event requests |
| chg_set | input | 7 | Change-flag set requests from port logic |
| rd_data | output | 32 | Current register value |
| port_reset_req | output | 1 | One-cycle port reset request |
| event_req | output | 1 | One-cycle port change event request |
| pls_dbg_ignored | output | 1 | One-cycle pulse on a rejected link-state value |

## Verification
A wrong link-state or flag register appears on `rd_data` in the cycle right after the write edge that caused it. A missed or spurious notification appears in that same cycle on `event_req`, and a pulse is never more than one cycle wide. Errors in ordering are visible on the next read. This applies to clear before notify, and to reset pre-empting everything else. The stimulus therefore always pairs one write with one sampled read, taken one edge later.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DW      = 32;
  localparam int PR_BIT  = 4;
  localparam int PLS_LSB = 5;
  localparam int PLSW    = 4;
  localparam int PP_BIT  = 9;
  localparam int LWS_BIT = 16;
  localparam int CHG_LSB = 17;
  localparam int NCHG    = 7;
  localparam int PLC_IDX = 5;
  localparam int WK_LSB  = 25;
  localparam int NWK     = 3;

  localparam logic [PLSW-1:0] LNK_U0     = 4'd0;
  localparam logic [PLSW-1:0] LNK_U3     = 4'd3;
  localparam logic [PLSW-1:0] LNK_RESUME = 4'd15;
endpackage

// File: rtl/psr_link_ctl.sv
module psr_link_ctl
  import psr_pkg::*;
#(
  parameter int W = PLSW
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] req,
  input  logic         strobe,
  output logic [W-1:0] nxt,
  output logic         enter_u0,
  output logic         bad_req
);
  always_comb begin
    nxt      = cur;
    enter_u0 = 1'b0;
    bad_req  = 1'b0;
    if (strobe) begin
      case (req)
        W'(LNK_U0): begin
          if (cur != W'(LNK_U0)) begin
            nxt      = req;
            enter_u0 = 1'b1;
          end
        end
        W'(LNK_U3): begin
          if (cur < W'(LNK_U3)) nxt = req;
        end
        W'(LNK_RESUME): ;
        default: bad_req = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/psr_field_upd.sv
module psr_field_upd #(
  parameter int NC = 7,
  parameter int NW = 3
) (
  input  logic          wr_ok,
  input  logic [NC-1:0] cur_chg,
  input  logic [NC-1:0] clr_mask,
  input  logic          pp_cur,
  input  logic          pp_wr,
  input  logic [NW-1:0] wk_cur,
  input  logic [NW-1:0] wk_wr,
  output logic [NC-1:0] chg_out,
  output logic          pp_nxt,
  output logic [NW-1:0] wk_nxt
);
  for (genvar i = 0; i < NC; i++) begin : g_w1c
    assign chg_out[i] = cur_chg[i] & ~(wr_ok & clr_mask[i]);
  end

  assign pp_nxt = wr_ok ? pp_wr : pp_cur;
  assign wk_nxt = wr_ok ? wk_wr : wk_cur;
endmodule

// File: rtl/psr_notify.sv
module psr_notify #(
  parameter int NC = 7
) (
  input  logic [NC-1:0] base,
  input  logic [NC-1:0] req,
  input  logic          run,
  output logic [NC-1:0] nxt,
  output logic          evt
);
  logic [NC-1:0] fresh;
  assign fresh = req & ~base;
  assign nxt   = base | req;
  assign evt   = run & (|fresh);
endmodule

// File: rtl/psr_port_status.sv
module psr_port_status
  import psr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          run,
  input  logic [6:0]    chg_set,
  output logic [31:0]   rd_data,
  output logic          port_reset_req,
  output logic          event_req,
  output logic          pls_dbg_ignored
);
  logic [PLSW-1:0] pls_q, pls_d;
  logic            pp_q, pp_d;
  logic [NWK-1:0]  wk_q, wk_d;
  logic [NCHG-1:0] chg_q, chg_d, chg_base, chg_req;
  logic            prst_q, prst_d, evt_q, evt_d, ign_q, ign_d;
  logic            is_rst_wr, wr_ok, lnk_strobe, enter_u0, bad_req;

  assign is_rst_wr  = wr_en & wr_data[PR_BIT];
  assign wr_ok      = wr_en & ~wr_data[PR_BIT];
  assign lnk_strobe = wr_ok & wr_data[LWS_BIT];

  psr_link_ctl #(.W(PLSW)) u_link (
    .cur      (pls_q),
    .req      (wr_data[PLS_LSB +: PLSW]),
    .strobe   (lnk_strobe),
    .nxt      (pls_d),
    .enter_u0 (enter_u0),
    .bad_req  (bad_req)
  );

  psr_field_upd #(.NC(NCHG), .NW(NWK)) u_fld (
    .wr_ok    (wr_ok),
    .cur_chg  (chg_q),
    .clr_mask (wr_data[CHG_LSB +: NCHG]),
    .pp_cur   (pp_q),
    .pp_wr    (wr_data[PP_BIT]),
    .wk_cur   (wk_q),
    .wk_wr    (wr_data[WK_LSB +: NWK]),
    .chg_out  (chg_base),
    .pp_nxt   (pp_d),
    .wk_nxt   (wk_d)
  );

  always_comb begin
    chg_req = chg_set;
    if (enter_u0) chg_req[PLC_IDX] = 1'b1;
  end

  psr_notify #(.NC(NCHG)) u_ntf (
    .base (chg_base),
    .req  (chg_req),
    .run  (run),
    .nxt  (chg_d),
    .evt  (evt_d)
  );

  assign prst_d = is_rst_wr;
  assign ign_d  = bad_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pls_q  <= '0;
      pp_q   <= 1'b0;
      wk_q   <= '0;
      chg_q  <= '0;
      prst_q <= 1'b0;
      evt_q  <= 1'b0;
      ign_q  <= 1'b0;
    end else begin
      if (wr_ok) begin
        pls_q <= pls_d;
        pp_q  <= pp_d;
        wk_q  <= wk_d;
      end
      chg_q  <= chg_d;
      prst_q <= prst_d;
      evt_q  <= evt_d;
      ign_q  <= ign_d;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[PLS_LSB +: PLSW] = pls_q;
    rd_data[PP_BIT]          = pp_q;
    rd_data[CHG_LSB +: NCHG] = chg_q;
    rd_data[WK_LSB +: NWK]   = wk_q;
  end

  assign port_reset_req  = prst_q;
  assign event_req       = evt_q;
  assign pls_dbg_ignored = ign_q;

  // R1
  rst_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[PR_BIT] && chg_set == '0) |=> (port_reset_req && rd_data == $past(rd_data)));
  // R3
  pls_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_data[PR_BIT] && wr_data[LWS_BIT]) |=> $stable(pls_q));
  // R4
  u0_plc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[PR_BIT] && wr_data[LWS_BIT] && wr_data[PLS_LSB +: PLSW] == LNK_U0
     && pls_q != LNK_U0) |=> rd_data[CHG_LSB + PLC_IDX]);
  // R5
  pls_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pls_q == LNK_U0) || (pls_q == LNK_U3));
  // R6
  ign_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pls_dbg_ignored |-> $past(wr_en && wr_data[LWS_BIT]));
  // R8
  evt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_req |-> $past(run));
endmodule

// File: tb/sim_psr_port_status.sv
module sim_psr_port_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        run = 1'b0;
  logic [6:0]  chg_set = '0;
  logic [31:0] rd_data;
  logic        port_reset_req, event_req, pls_dbg_ignored;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  psr_port_status u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .run(run),
    .chg_set(chg_set), .rd_data(rd_data), .port_reset_req(port_reset_req),
    .event_req(event_req), .pls_dbg_ignored(pls_dbg_ignored)
  );

  typedef struct packed {
    logic        we;
    logic [31:0] data;
    logic        run;
    logic [6:0]  set;
    logic [31:0] exp_rd;
    logic        exp_evt;
    logic        exp_prst;
    logic        exp_ign;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0E000200, 1'b1, 7'h00, 32'h0E000200, 1'b0, 1'b0, 1'b0, 8'd7}, // R7 set
    '{1'b1, 32'h00000000, 1'b1, 7'h00, 32'h00000000, 1'b0, 1'b0, 1'b0, 8'd7}, // R7 clear
    '{1'b1, 32'h00000060, 1'b1, 7'h00, 32'h00000000, 1'b0, 1'b0, 1'b0, 8'd3}, // R3 no strobe
    '{1'b1, 32'h00010060, 1'b1, 7'h00, 32'h00000060, 1'b0, 1'b0, 1'b0, 8'd5}, // R5 U0->U3
    '{1'b1, 32'h00010260, 1'b1, 7'h00, 32'h00000260, 1'b0, 1'b0, 1'b0, 8'd5}, // R5 U3->U3 ignored
    '{1'b1, 32'h000103E0, 1'b1, 7'h00, 32'h00000260, 1'b0, 1'b0, 1'b0, 8'd6}, // R6 resume
    '{1'b1, 32'h000102A0, 1'b1, 7'h00, 32'h00000260, 1'b0, 1'b0, 1'b1, 8'd6}, // R6 value 5
    '{1'b1, 32'h00010200, 1'b1, 7'h00, 32'h00400200, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 U3->U0
    '{1'b1, 32'h00400200, 1'b1, 7'h00, 32'h00000200, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 clear PLC
    '{1'b0, 32'h00000000, 1'b1, 7'h01, 32'h00020200, 1'b1, 1'b0, 1'b0, 8'd8}, // R8 new flag
    '{1'b0, 32'h00000000, 1'b1, 7'h01, 32'h00020200, 1'b0, 1'b0, 1'b0, 8'd8}, // R8 already set
    '{1'b0, 32'h00000000, 1'b1, 7'h03, 32'h00060200, 1'b1, 1'b0, 1'b0, 8'd8}, // R8 one new
    '{1'b1, 32'h00020200, 1'b1, 7'h00, 32'h00040200, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 zero keeps
    '{1'b1, 32'h02050270, 1'b1, 7'h00, 32'h00040200, 1'b0, 1'b1, 1'b0, 8'd1}, // R1 pre-empt
    '{1'b1, 32'h00010260, 1'b0, 7'h00, 32'h00040260, 1'b0, 1'b0, 1'b0, 8'd5}, // R5 again
    '{1'b1, 32'h00010200, 1'b0, 7'h00, 32'h00440200, 1'b0, 1'b0, 1'b0, 8'd8}, // R8 no run
    '{1'b1, 32'h00010260, 1'b1, 7'h00, 32'h00440260, 1'b0, 1'b0, 1'b0, 8'd5}, // R5 to U3
    '{1'b1, 32'h00410200, 1'b1, 7'h00, 32'h00440200, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 clear then set
    '{1'b1, 32'h00010200, 1'b1, 7'h00, 32'h00440200, 1'b0, 1'b0, 1'b0, 8'd4}, // R4 U0->U0
    '{1'b1, 32'h00440200, 1'b1, 7'h00, 32'h00000200, 1'b0, 1'b0, 1'b0, 8'd2}, // R2 clear two
    '{1'b0, 32'hFFFFFFFF, 1'b1, 7'h00, 32'h00000200, 1'b0, 1'b0, 1'b0, 8'd3}  // R3 no write
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(9, "rd_data in reset", rd_data, 32'h0);
    chk(9, "pulses in reset", {29'h0, port_reset_req, event_req, pls_dbg_ignored}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      wr_en   = VECS[i].we;
      wr_data = VECS[i].data;
      run     = VECS[i].run;
      chg_set = VECS[i].set;
      @(posedge clk);
      @(negedge clk);
      chk(int'(VECS[i].req), $sformatf("row %0d rd_data", i), rd_data, VECS[i].exp_rd);
      chk(int'(VECS[i].req), $sformatf("row %0d event_req", i), {31'h0, event_req}, {31'h0, VECS[i].exp_evt});
      chk(int'(VECS[i].req), $sformatf("row %0d port_reset_req", i), {31'h0, port_reset_req}, {31'h0, VECS[i].exp_prst});
      chk(int'(VECS[i].req), $sformatf("row %0d pls_dbg_ignored", i), {31'h0, pls_dbg_ignored}, {31'h0, VECS[i].exp_ign});
    end
    wr_en = 1'b0; chg_set = '0;
    // R1 pulse is a single cycle
    wr_en = 1'b1; wr_data = 32'h00000010;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk(1, "reset pulse high", {31'h0, port_reset_req}, 32'h1);
    @(posedge clk); @(negedge clk);
    chk(1, "reset pulse width", {31'h0, port_reset_req}, 32'h0);
    // R9 asynchronous reset mid-run clears register
    wr_en = 1'b1; wr_data = 32'h0E000200;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk(9, "rd_data after reset", rd_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(9, "rd_data after release", rd_data, 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule